// File: doc/BRIEF.md
# Paired Interleaved Bank Controller

This block fronts a word-addressed memory built from four banks. Each bank runs its own access cycle and is grouped with one other bank into a pair. Inside a pair, neighbouring word addresses land in opposite banks. Instruction fetches read a whole pair at once, getting an even word and an odd word in the same cycle. Operand accesses, reads or writes, touch a single bank. When code sits in one pair and data in the other, a fetch and an operand access can both start on the same clock.

There are two request channels, each with a valid/ready handshake:
- **Fetch channel.** Carries a pair-row address.
- **Operand channel.** Carries a word address, a write flag and write data.

Back-pressure rules:
- A requester raises valid and holds valid and every request field steady until it sees ready high at a rising edge. That edge is the handshake.
- Ready may be high while valid is low.
- Ready falls whenever a bank that the request needs is still inside its cycle.
- The two response channels carry a valid strobe only. They cannot be stalled, and the consumer takes the data in the cycle the strobe is high.

Each bank holds a down-counter. Once a bank has been issued an access, it will not accept another until CYCLE clocks have passed. When a fetch and an operand access want the same pair in the same cycle and both could issue, the one that has been waiting longer goes first. If neither has been waiting, the fetch goes first. Read data is held in the bank's output register until that bank's next read. For this reason the parameters must satisfy LAT ≤ CYCLE.

Top module: `paired_bank_ctrl`

## Requirements
- R1: In the first cycle after reset, neither response valid is high and both ready outputs are high.
- R2: An operand address maps its fields as follows: bit AW-1 selects the pair, bit 0 selects the bank within the pair, and bits AW-2..1 select the row. A word written to any address is returned by a later operand read of the same address.
- R3: A read of a location that has not been written since reset returns zero.
- R4: Fetch address p (AW-1 bits, whose top bit is the pair) returns word 2p on the even output and word 2p+1 on the odd output, both under one response strobe.
- R5: A read accepted at rising edge k raises its response valid for the cycle after edge k+LAT-1 and not before. An accepted write produces no response.
- R6: After a bank is issued an access at edge k, it accepts its next access no earlier than edge k+CYCLE. A request to a bank that is idle is accepted at the next edge.
- R7: A fetch occupies both banks of its pair. An operand access to either bank of that pair is not accepted until CYCLE edges later.
- R8: A fetch and an operand access that target different pairs, with all the banks they need idle, are both accepted at the same edge.
- R9: When a fetch and an operand access to the same pair arrive together and neither has been waiting, the fetch is accepted first. The operand access is accepted CYCLE edges later.
- R10: An operand access that was stalled in the previous cycle is accepted ahead of a fetch to the same pair that has just arrived, once its bank becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Fetch request accepted at this edge when valid |
| fetch_addr | input | AW-1 | Pair-row address; top bit picks the pair |
| fetch_rsp_valid | output | 1 | Fetch response strobe |
| fetch_rsp_even | output | DW | Word at address 2p |
| fetch_rsp_odd | output | DW | Word at address 2p+1 |
| opnd_valid | input | 1 | Operand request valid |
| opnd_ready | output | 1 | Operand request accepted at this edge when valid |
| opnd_we | input | 1 | 1 = write, 0 = read |
| opnd_addr | input | AW | Word address |
| opnd_wdata | input | DW | Write data |
| opnd_rsp_valid | output | 1 | Operand read response strobe |
| opnd_rsp_data | output | DW | Operand read data |

## Verification
The hardest case to reach is R10. It needs an operand request that is already stalled behind a busy bank, and a fetch to the same pair that first appears in exactly the cycle before that bank frees. The bench issues one operand access and counts edges from its handshake. It then queues a second operand access to the same bank and raises the fetch on the last busy cycle. At that point both requests can issue and only the waiting flag separates them. The bench checks the handshake edge of each against arithmetic offsets of CYCLE.

// File: rtl/pb_pkg.sv
package pb_pkg;
  localparam int NBANK = 4;

  typedef logic [1:0] bank_t;

  function automatic bank_t bank_of(input logic pair, input logic lane);
    return {pair, lane};
  endfunction

  function automatic logic [NBANK-1:0] pair_mask(input logic pair);
    return pair ? 4'b1100 : 4'b0011;
  endfunction

  function automatic logic [NBANK-1:0] bank_mask(input bank_t b);
    return 4'b0001 << b;
  endfunction
endpackage

// File: rtl/pb_bank_timer.sv
module pb_bank_timer #(
  parameter int CYCLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  output logic busy
);
  localparam int CW = $clog2(CYCLE + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (issue) begin
      remain <= CW'(CYCLE - 1);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/pb_bank_mem.sv
module pb_bank_mem #(
  parameter int RW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << RW;

  logic [DW-1:0] cells [DEPTH];

  // Read data stays in rdata until the next read of this bank.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      rdata <= '0;
    end else if (en) begin
      if (we) cells[row] <= wdata;
      else    rdata      <= cells[row];
    end
  end
endmodule

// File: rtl/pb_delay.sv
module pb_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/pb_arbiter.sv
module pb_arbiter
  import pb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic             fetch_pair,
  input  logic             opnd_valid,
  input  bank_t            opnd_bank,
  input  logic [NBANK-1:0] busy,
  output logic             fetch_ready,
  output logic             opnd_ready,
  output logic             fetch_go,
  output logic             opnd_go,
  output logic [NBANK-1:0] issue
);
  logic [NBANK-1:0] f_need, o_need;
  logic f_free, o_free, clash, op_first;
  logic f_wait, o_wait;

  assign f_need   = pair_mask(fetch_pair);
  assign o_need   = bank_mask(opnd_bank);
  assign f_free   = ~|(busy & f_need);
  assign o_free   = ~|(busy & o_need);
  assign clash    = |(f_need & o_need);
  assign op_first = o_wait & ~f_wait;

  assign fetch_ready = f_free & ~(clash & opnd_valid & o_free & op_first);
  assign opnd_ready  = o_free & ~(clash & fetch_valid & f_free & ~op_first);
  assign fetch_go    = fetch_valid & fetch_ready;
  assign opnd_go     = opnd_valid & opnd_ready;
  assign issue       = (fetch_go ? f_need : '0) | (opnd_go ? o_need : '0);

  // One bit per channel records that it stalled last cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      f_wait <= 1'b0;
      o_wait <= 1'b0;
    end else begin
      f_wait <= fetch_valid & ~fetch_ready;
      o_wait <= opnd_valid & ~opnd_ready;
    end
  end
endmodule

// File: rtl/paired_bank_ctrl.sv
module paired_bank_ctrl
  import pb_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int CYCLE = 4,
  parameter int LAT   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  output logic          fetch_ready,
  input  logic [AW-2:0] fetch_addr,
  output logic          fetch_rsp_valid,
  output logic [DW-1:0] fetch_rsp_even,
  output logic [DW-1:0] fetch_rsp_odd,
  input  logic          opnd_valid,
  output logic          opnd_ready,
  input  logic          opnd_we,
  input  logic [AW-1:0] opnd_addr,
  input  logic [DW-1:0] opnd_wdata,
  output logic          opnd_rsp_valid,
  output logic [DW-1:0] opnd_rsp_data
);
  localparam int RW = AW - 2;

  logic          fetch_pair;
  logic [RW-1:0] fetch_row, opnd_row;
  bank_t         opnd_bank;

  assign fetch_pair = fetch_addr[AW-2];
  assign fetch_row  = fetch_addr[RW-1:0];
  assign opnd_row   = opnd_addr[AW-2:1];
  assign opnd_bank  = bank_of(opnd_addr[AW-1], opnd_addr[0]);

  logic [NBANK-1:0] bank_busy, bank_issue;
  logic             fetch_go, opnd_go;

  pb_arbiter u_arb (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .fetch_pair  (fetch_pair),
    .opnd_valid  (opnd_valid),
    .opnd_bank   (opnd_bank),
    .busy        (bank_busy),
    .fetch_ready (fetch_ready),
    .opnd_ready  (opnd_ready),
    .fetch_go    (fetch_go),
    .opnd_go     (opnd_go),
    .issue       (bank_issue)
  );

  logic [DW-1:0] bank_rdata [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic by_opnd;
    assign by_opnd = opnd_go && (opnd_bank == bank_t'(b));

    pb_bank_timer #(.CYCLE(CYCLE)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .issue (bank_issue[b]),
      .busy  (bank_busy[b])
    );

    pb_bank_mem #(.RW(RW), .DW(DW)) u_mem (
      .clk   (clk),
      .rst   (rst),
      .en    (bank_issue[b]),
      .we    (by_opnd && opnd_we),
      .row   (by_opnd ? opnd_row : fetch_row),
      .wdata (opnd_wdata),
      .rdata (bank_rdata[b])
    );
  end

  // Tags travel LAT stages; data is picked from the holding bank at the end.
  logic [2:0] op_tag_in, op_tag_q;
  logic [1:0] f_tag_in, f_tag_q;

  assign op_tag_in = {opnd_go && !opnd_we, opnd_bank};
  assign f_tag_in  = {fetch_go, fetch_pair};

  pb_delay #(.W(3), .DEPTH(LAT)) u_op_dly (
    .clk (clk), .rst (rst), .din (op_tag_in), .dout (op_tag_q)
  );

  pb_delay #(.W(2), .DEPTH(LAT)) u_f_dly (
    .clk (clk), .rst (rst), .din (f_tag_in), .dout (f_tag_q)
  );

  assign opnd_rsp_valid  = op_tag_q[2];
  assign opnd_rsp_data   = bank_rdata[op_tag_q[1:0]];
  assign fetch_rsp_valid = f_tag_q[1];
  assign fetch_rsp_even  = bank_rdata[bank_of(f_tag_q[0], 1'b0)];
  assign fetch_rsp_odd   = bank_rdata[bank_of(f_tag_q[0], 1'b1)];
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int AW    = 6,
  parameter int CYCLE = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_valid,
  input logic          fetch_ready,
  input logic [AW-2:0] fetch_addr,
  input logic          fetch_rsp_valid,
  input logic          opnd_valid,
  input logic          opnd_ready,
  input logic [AW-1:0] opnd_addr,
  input logic          opnd_rsp_valid,
  input logic [3:0]    bank_issue,
  input logic [3:0]    bank_busy
);
  logic [1:0] ob, fe, fo;
  assign ob = {opnd_addr[AW-1], opnd_addr[0]};
  assign fe = {fetch_addr[AW-2], 1'b0};
  assign fo = {fetch_addr[AW-2], 1'b1};

  // R1: quiet and ready straight after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fetch_rsp_valid && !opnd_rsp_valid && fetch_ready && opnd_ready));

  // R7: an accepted fetch starts both banks of its pair
  p_pair_issue_r7: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_ready) |-> (bank_issue[fe] && bank_issue[fo]));

  // R9: two accepted requests in one cycle never share a pair
  p_split_pairs_r9: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_ready && opnd_valid && opnd_ready)
      |-> (opnd_addr[AW-1] != fetch_addr[AW-2]));

  // R10: a waiting operand beats a fresh fetch to the same pair
  p_arrival_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(opnd_valid && !opnd_ready) && !$past(fetch_valid && !fetch_ready)
      && opnd_valid && fetch_valid && (opnd_addr[AW-1] == fetch_addr[AW-2])
      && !bank_busy[ob] && !bank_busy[fe] && !bank_busy[fo])
      |-> (opnd_ready && !fetch_ready));

  // R6: issue spacing per bank, measured by a counter
  int since [4];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 4; b++) since[b] <= CYCLE;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (bank_issue[b])       since[b] <= 1;
        else if (since[b] < CYCLE) since[b] <= since[b] + 1;
      end
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_gap
    p_bank_gap_r6: assert property (@(posedge clk) disable iff (rst)
      bank_issue[b] |-> (since[b] >= CYCLE));
  end
endmodule

bind paired_bank_ctrl pb_checker #(.AW(AW), .CYCLE(CYCLE)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .fetch_valid     (fetch_valid),
  .fetch_ready     (fetch_ready),
  .fetch_addr      (fetch_addr),
  .fetch_rsp_valid (fetch_rsp_valid),
  .opnd_valid      (opnd_valid),
  .opnd_ready      (opnd_ready),
  .opnd_addr       (opnd_addr),
  .opnd_rsp_valid  (opnd_rsp_valid),
  .bank_issue      (bank_issue),
  .bank_busy       (bank_busy)
);

// File: tb/paired_bank_ctrl_tb.sv
module paired_bank_ctrl_tb;
  localparam int AW = 6, DW = 16, CYCLE = 4, LAT = 2;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic fetch_valid = 1'b0, fetch_ready;
  logic [AW-2:0] fetch_addr = '0;
  logic fetch_rsp_valid;
  logic [DW-1:0] fetch_rsp_even, fetch_rsp_odd;
  logic opnd_valid = 1'b0, opnd_ready, opnd_we = 1'b0;
  logic [AW-1:0] opnd_addr = '0;
  logic [DW-1:0] opnd_wdata = '0;
  logic opnd_rsp_valid;
  logic [DW-1:0] opnd_rsp_data;

  int cyc = 0, errors = 0, checks = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  paired_bank_ctrl #(.AW(AW), .DW(DW), .CYCLE(CYCLE), .LAT(LAT)) u_dut (.*);

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 40503 + 17);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic op_go(input bit we, input int a, input logic [DW-1:0] d, output int hs);
    @(negedge clk);
    opnd_valid = 1'b1; opnd_we = we; opnd_addr = AW'(a); opnd_wdata = d;
    #1;
    while (!opnd_ready) begin @(negedge clk); #1; end
    hs = cyc + 1;
    @(posedge clk); #1;
    opnd_valid = 1'b0;
  endtask

  task automatic if_go(input int p, output int hs);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = (AW-1)'(p);
    #1;
    while (!fetch_ready) begin @(negedge clk); #1; end
    hs = cyc + 1;
    @(posedge clk); #1;
    fetch_valid = 1'b0;
  endtask

  task automatic op_write(input int a, input logic [DW-1:0] d);
    int hs;
    op_go(1'b1, a, d, hs);
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      chk(!opnd_rsp_valid, "R5", "write gave response", opnd_rsp_valid, 0);
    end
  endtask

  task automatic op_read(input int a, input logic [DW-1:0] exp, input string req);
    int hs;
    op_go(1'b0, a, '0, hs);
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      if (i == LAT - 1) begin
        chk(opnd_rsp_valid, "R5", "read response missing", opnd_rsp_valid, 1);
        chk(opnd_rsp_data == exp, req, "read data", opnd_rsp_data, exp);
      end else begin
        chk(!opnd_rsp_valid, "R5", "read response early", opnd_rsp_valid, 0);
      end
    end
  endtask

  task automatic if_read(input int p, input logic [DW-1:0] ev, input logic [DW-1:0] od,
                         input string req);
    int hs;
    if_go(p, hs);
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      if (i == LAT - 1) begin
        chk(fetch_rsp_valid, "R5", "fetch response missing", fetch_rsp_valid, 1);
        chk(fetch_rsp_even == ev, req, "fetch even word", fetch_rsp_even, ev);
        chk(fetch_rsp_odd == od, req, "fetch odd word", fetch_rsp_odd, od);
      end else begin
        chk(!fetch_rsp_valid, "R5", "fetch response early", fetch_rsp_valid, 0);
      end
    end
  endtask

  task automatic settle();
    repeat (CYCLE + LAT + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    int a0, b0, c0, d0, e0, h1, h2, w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(fetch_ready, "R1", "fetch_ready after reset", fetch_ready, 1);
    chk(opnd_ready, "R1", "opnd_ready after reset", opnd_ready, 1);
    chk(!fetch_rsp_valid, "R1", "fetch_rsp_valid after reset", fetch_rsp_valid, 0);
    chk(!opnd_rsp_valid, "R1", "opnd_rsp_valid after reset", opnd_rsp_valid, 0);

    // R3: unwritten locations read zero
    op_read(0, '0, "R3");
    op_read(NW - 1, '0, "R3");
    op_read(21, '0, "R3");
    if_read(7, '0, '0, "R3");

    // R2: full write then read sweep over every address
    for (int a = 0; a < NW; a++) op_write(a, pat(a));
    for (int a = 0; a < NW; a++) op_read(a, pat(a), "R2");
    // R4: every pair-row fetch
    for (int p = 0; p < NW / 2; p++) if_read(p, pat(2 * p), pat(2 * p + 1), "R4");

    // R6 / R7: bank cycle spacing
    settle();
    op_go(1'b1, 0, pat(0), a0);
    op_go(1'b0, 2, '0, b0);
    chk(b0 - a0 == CYCLE, "R6", "same-bank spacing", b0 - a0, CYCLE);
    op_go(1'b0, 1, '0, c0);
    chk(c0 - b0 == 1, "R6", "idle-bank spacing", c0 - b0, 1);
    if_go(0, d0);
    chk(d0 - c0 == CYCLE, "R7", "fetch waits for pair", d0 - c0, CYCLE);
    op_go(1'b0, 3, '0, e0);
    chk(e0 - d0 == CYCLE, "R7", "operand after fetch on pair", e0 - d0, CYCLE);

    // R8: different pairs issue together
    settle();
    fork
      if_go(16 + 3, h1);
      op_go(1'b0, 4, '0, h2);
    join
    chk(h1 == h2, "R8", "concurrent issue edge", h2, h1);

    // R9: same pair, simultaneous arrival, fetch first
    settle();
    fork
      if_go(1, h1);
      op_go(1'b0, 9, '0, h2);
    join
    chk(h2 - h1 == CYCLE, "R9", "operand delayed behind fetch", h2 - h1, CYCLE);

    // R10: waiting operand beats a fresh fetch
    settle();
    op_go(1'b0, 0, '0, w0);
    fork
      op_go(1'b0, 2, '0, h2);
      begin
        do @(negedge clk); while (cyc != w0 + 2);
        if_go(0, h1);
      end
    join
    chk(h2 - w0 == CYCLE, "R10", "waiting operand issue edge", h2 - w0, CYCLE);
    chk(h1 - w0 == 2 * CYCLE, "R10", "fresh fetch issue edge", h1 - w0, 2 * CYCLE);

    settle();
    finish_run();
  end
endmodule